// File: doc/BRIEF.md
# Multi-Width ALU with Status Flags and Repeat Sequencer

This block is the two-operand execution unit of a small 16-bit-class microcontroller core. It runs twelve operations: move, binary add with and without carry, binary subtract with and without borrow, compare, packed-decimal add, bit test, AND, bit clear, bit set and XOR. Each operation works on 8, 16 or 20-bit operands. It returns a result masked to the selected width, a write-enable for that result and an updated set of V, N, Z and C flags.

The operands and flags arrive already fetched. A one-cycle `start` pulse loads them. An internal sequencer then runs one or more iterations. It runs more than one only when both operands are registers and a repeat count was given. Each iteration feeds its masked result back as the next destination operand. It also feeds the result back as the source when source and destination name the same register. A zero-carry option forces the carry input of carry-using operations to 0 on every iteration.

Top module: `mw_alu`

## Requirements
- R1: `wsel` picks the width: 0 gives 8 bits, 1 gives 16 bits, 2 or 3 gives 20 bits. Input operands and the result are masked to that width. The sign bit is the top bit of the width.
- R2: Carry-in is 0 for add (code 1) and 1 for subtract (3) and compare (5). For those two the masked source is inverted first. Add-with-carry (2) and subtract-with-carry (4) take their carry-in from the C flag.
- R3: `flags_in` and `flags_out` are packed as {V,N,Z,C}, with V in bit 3. For add, add-with-carry, subtract, subtract-with-carry and compare, the flags are set as follows. Z is set when the masked result is 0. N is the sign bit. C is the sum bit one above the sign bit. V is the sign-bit position of src' ^ dst ^ sum ^ (sum >> 1), where src' is the source after any inversion.
- R4: AND (8) and bit test (7) clear V, set N from the sign bit, and set exactly one of C (result non-zero) or Z (result zero). XOR (11) follows the same rule, except that it sets V when both operands have their sign bit set.
- R5: Move (0), bit clear (9) and bit set (10) leave all four flags as they were. Compare and bit test finish with `wr_en` low.
- R6: Decimal add (6) adds nibble by nibble, starting from the C flag. A nibble sum above 9 gets 6 added and carries 1 into the next nibble. C is the carry out of the top nibble of the width, Z and N follow R3, and V is cleared.
- R7: The iteration count is `rpt_reg`+1 when `rpt_use_reg` is set, and `rpt_imm`+1 otherwise. It applies only when `both_reg` is high. Otherwise exactly one iteration runs.
- R8: With `zc` high and `both_reg` high, the carry-in of add-with-carry, subtract-with-carry and decimal add is 0 on every iteration. With `both_reg` low, `zc` has no effect.
- R9: Each iteration after the first uses the previous masked result as the destination operand, and the flags the previous iteration produced. When `same_reg` is high, it uses that result as the source operand as well.
- R10: A `start` pulse while idle loads the operands. `busy` is then high for exactly one cycle per iteration. `done` pulses for one cycle right after the last iteration, with `result` and `flags_out` final. `wr_en` is high only in that `done` cycle. A `start` pulse while busy is ignored.
- R11: Opcodes 12 to 15 are unused. They finish with `wr_en` low and the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load operands and begin (ignored while busy) |
| op | input | 4 | Opcode (see R2 to R6, R11) |
| wsel | input | 2 | Width select (R1) |
| src_in | input | 20 | Source operand |
| dst_in | input | 20 | Destination operand |
| flags_in | input | 4 | Incoming flags {V,N,Z,C} |
| both_reg | input | 1 | Both operands are registers; enables repeat and zero-carry |
| rpt_use_reg | input | 1 | Take repeat count from `rpt_reg` instead of `rpt_imm` |
| rpt_imm | input | 4 | Immediate repeat count minus one |
| rpt_reg | input | 4 | Low four bits of the count register |
| same_reg | input | 1 | Source and destination are the same register |
| zc | input | 1 | Zero-carry option |
| result | output | 20 | Masked result of the last iteration |
| wr_en | output | 1 | Result must be written back (one cycle, with done) |
| flags_out | output | 4 | Current flags {V,N,Z,C} |
| busy | output | 1 | An iteration is executing this cycle |
| done | output | 1 | One-cycle strobe after the last iteration |

## Verification
Signed overflow into the sign bit at 16 bits checks V and N. A design with a wrong V formula or a wrong sign position would report no overflow. An 8-bit add that wraps to zero, with junk loaded into the upper source bits, would expose missing input masking through a non-zero result or a lost carry. Decimal adds that ripple through two nibbles, and one that carries out of the top of an 8-bit width, catch a missing +6 correction or a carry taken from the wrong nibble. The repeat cases count `busy` cycles and check the accumulated result. They use immediate and register counts, same-register feedback, and a carry chain across iterations with and without zero-carry. A sequencer that is off by one, feeds back stale operands or ignores the carry mask would give a different sum or cycle count.

// File: rtl/mw_alu_pkg.sv
package mw_alu_pkg;
    localparam int DW  = 20;       // widest operand
    localparam int NIB = DW / 4;   // decimal digits at full width
    localparam int CW  = 4;        // repeat count field width

    typedef enum logic [3:0] {
        OP_MOV  = 4'd0,  OP_ADD  = 4'd1,  OP_ADDC = 4'd2,  OP_SUB = 4'd3,
        OP_SUBC = 4'd4,  OP_CMP  = 4'd5,  OP_DADD = 4'd6,  OP_BIT = 4'd7,
        OP_AND  = 4'd8,  OP_BIC  = 4'd9,  OP_BIS  = 4'd10, OP_XOR = 4'd11,
        OP_R12  = 4'd12, OP_R13  = 4'd13, OP_R14  = 4'd14, OP_R15 = 4'd15
    } op_e;

    typedef struct packed {
        logic v;
        logic n;
        logic z;
        logic c;
    } flags_t;

    function automatic logic [DW-1:0] width_mask(input logic [1:0] w);
        case (w)
            2'd0:    return DW'(8'hFF);
            2'd1:    return DW'(16'hFFFF);
            default: return {DW{1'b1}};
        endcase
    endfunction

    function automatic logic [4:0] sign_pos(input logic [1:0] w);
        case (w)
            2'd0:    return 5'd7;
            2'd1:    return 5'd15;
            default: return 5'(DW - 1);
        endcase
    endfunction
endpackage

// File: rtl/mw_alu_bcd.sv
module mw_alu_bcd #(
    parameter int DIGITS = 5
) (
    input  logic [4*DIGITS-1:0] a,
    input  logic [4*DIGITS-1:0] b,
    input  logic                cin,
    output logic [4*DIGITS-1:0] y,
    output logic [DIGITS-1:0]   cout
);
    logic [DIGITS:0] chain;
    assign chain[0] = cin;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        logic [4:0] raw;
        logic       fix;
        assign raw  = {1'b0, a[4*g +: 4]} + {1'b0, b[4*g +: 4]} + {4'd0, chain[g]};
        assign fix  = (raw > 5'd9);
        assign y[4*g +: 4] = fix ? (raw[3:0] + 4'd6) : raw[3:0];
        assign chain[g+1]  = fix;
        assign cout[g]     = fix;
    end
endmodule

// File: rtl/mw_alu_core.sv
module mw_alu_core
    import mw_alu_pkg::*;
(
    input  op_e           op,
    input  logic [1:0]    wsel,
    input  logic [DW-1:0] src,
    input  logic [DW-1:0] dst,
    input  flags_t        fin,
    input  logic          carry_mask,   // 1 forces carry-in of carry-using ops to 0
    output logic [DW-1:0] res,
    output flags_t        fout,
    output logic          we
);
    logic [DW-1:0] mask, s_m, d_m, s_op, vx, bcd_y;
    logic [DW:0]   sum;
    logic [4:0]    sp;
    logic [2:0]    top_dig;
    logic          ci, c_use, inv;
    logic [NIB-1:0] bcd_c;

    assign mask    = width_mask(wsel);
    assign sp      = sign_pos(wsel);
    assign top_dig = 3'(sp >> 2);
    assign s_m     = src & mask;
    assign d_m     = dst & mask;
    assign c_use   = fin.c & ~carry_mask;
    assign inv     = (op == OP_SUB) || (op == OP_SUBC) || (op == OP_CMP);
    assign s_op    = inv ? (s_m ^ mask) : s_m;

    always_comb begin
        case (op)
            OP_SUB, OP_CMP:   ci = 1'b1;
            OP_ADDC, OP_SUBC: ci = c_use;
            default:          ci = 1'b0;
        endcase
    end

    assign sum = {1'b0, s_op} + {1'b0, d_m} + {{DW{1'b0}}, ci};
    assign vx  = s_op ^ d_m ^ sum[DW-1:0] ^ sum[DW:1];

    mw_alu_bcd #(.DIGITS(NIB)) u_bcd (
        .a(s_m), .b(d_m), .cin(c_use), .y(bcd_y), .cout(bcd_c)
    );

    always_comb begin
        res  = d_m;
        fout = fin;
        we   = 1'b1;
        case (op)
            OP_MOV: res = s_m;
            OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP: begin
                res    = sum[DW-1:0] & mask;
                fout.z = (res == '0);
                fout.n = res[sp];
                fout.c = sum[sp + 5'd1];
                fout.v = vx[sp];
                we     = (op != OP_CMP);
            end
            OP_DADD: begin
                res    = bcd_y & mask;
                fout.z = (res == '0);
                fout.n = res[sp];
                fout.c = bcd_c[top_dig];
                fout.v = 1'b0;
            end
            OP_BIT, OP_AND, OP_XOR: begin
                res    = (op == OP_XOR) ? (s_m ^ d_m) : (s_m & d_m);
                fout.z = (res == '0);
                fout.c = (res != '0);
                fout.n = res[sp];
                fout.v = (op == OP_XOR) ? (s_m[sp] & d_m[sp]) : 1'b0;
                we     = (op != OP_BIT);
            end
            OP_BIC: res = d_m & ~s_m;
            OP_BIS: res = d_m | s_m;
            default: we = 1'b0;
        endcase
    end
endmodule

// File: rtl/mw_alu.sv
module mw_alu
    import mw_alu_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [3:0]    op,
    input  logic [1:0]    wsel,
    input  logic [19:0]   src_in,
    input  logic [19:0]   dst_in,
    input  logic [3:0]    flags_in,
    input  logic          both_reg,
    input  logic          rpt_use_reg,
    input  logic [3:0]    rpt_imm,
    input  logic [3:0]    rpt_reg,
    input  logic          same_reg,
    input  logic          zc,
    output logic [19:0]   result,
    output logic          wr_en,
    output logic [3:0]    flags_out,
    output logic          busy,
    output logic          done
);
    typedef struct packed {
        logic          busy;
        logic          done;
        logic          wr_en;
        logic [CW-1:0] left;
        op_e           op;
        logic [1:0]    w;
        logic          same;
        logic          zc;
        logic [DW-1:0] src;
        logic [DW-1:0] dst;
        logic [DW-1:0] result;
        flags_t        flags;
    } st_t;

    st_t           st_q, st_d;
    logic [DW-1:0] core_res;
    flags_t        core_flags;
    logic          core_we;

    mw_alu_core u_core (
        .op(st_q.op), .wsel(st_q.w), .src(st_q.src), .dst(st_q.dst),
        .fin(st_q.flags), .carry_mask(st_q.zc),
        .res(core_res), .fout(core_flags), .we(core_we)
    );

    always_comb begin
        st_d       = st_q;
        st_d.done  = 1'b0;
        st_d.wr_en = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy  = 1'b1;
                st_d.op    = op_e'(op);
                st_d.w     = wsel;
                st_d.src   = src_in;
                st_d.dst   = dst_in;
                st_d.flags = flags_t'(flags_in);
                st_d.same  = same_reg;
                st_d.zc    = both_reg & zc;
                st_d.left  = both_reg ? (rpt_use_reg ? rpt_reg : rpt_imm) : '0;
            end
        end else begin
            st_d.flags = core_flags;
            st_d.dst   = core_res;
            if (st_q.same)
                st_d.src = core_res;
            if (st_q.left == '0) begin
                st_d.busy   = 1'b0;
                st_d.done   = 1'b1;
                st_d.wr_en  = core_we;
                st_d.result = core_res;
            end else begin
                st_d.left = st_q.left - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.op <= OP_MOV;
        end else begin
            st_q <= st_d;
        end
    end

    assign result    = st_q.result;
    assign wr_en     = st_q.wr_en;
    assign flags_out = st_q.flags;
    assign busy      = st_q.busy;
    assign done      = st_q.done;

    AST_RESULT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((result & ~width_mask(st_q.w)) == '0));                        // R1
    AST_LOGIC_ZC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        done && (st_q.op == OP_AND || st_q.op == OP_BIT || st_q.op == OP_XOR)
        |-> (flags_out[1] != flags_out[0]));                                     // R4
    AST_NO_WRITE_CMP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        done && (st_q.op == OP_CMP || st_q.op == OP_BIT) |-> !wr_en);            // R5
    AST_FLAGS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        busy && (st_q.op == OP_MOV || st_q.op == OP_BIS || st_q.op == OP_BIC)
        |=> $stable(flags_out));                                                 // R5
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));                                        // R10
    AST_WE_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> done);                                                         // R10
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> busy);                                                // R10
endmodule

// File: tb/mw_alu_test.sv
module mw_alu_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  op = '0;
    logic [1:0]  wsel = '0;
    logic [19:0] src_in = '0, dst_in = '0;
    logic [3:0]  flags_in = '0;
    logic        both_reg = 1'b0, rpt_use_reg = 1'b0, same_reg = 1'b0, zc = 1'b0;
    logic [3:0]  rpt_imm = '0, rpt_reg = '0;
    logic [19:0] result;
    logic        wr_en, busy, done;
    logic [3:0]  flags_out;

    int tests = 0;
    int fails = 0;
    int busy_cycles;

    always #5 clk = ~clk;

    mw_alu uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .wsel(wsel),
        .src_in(src_in), .dst_in(dst_in), .flags_in(flags_in),
        .both_reg(both_reg), .rpt_use_reg(rpt_use_reg), .rpt_imm(rpt_imm),
        .rpt_reg(rpt_reg), .same_reg(same_reg), .zc(zc),
        .result(result), .wr_en(wr_en), .flags_out(flags_out),
        .busy(busy), .done(done)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Issue one operation and wait for done; samples at negedges.
    task automatic run(input logic [3:0] o, input logic [1:0] w,
                       input logic [19:0] s, input logic [19:0] d, input logic [3:0] f,
                       input logic br, input logic ur, input logic [3:0] ri,
                       input logic [3:0] rr, input logic sr, input logic z);
        @(negedge clk);
        op = o; wsel = w; src_in = s; dst_in = d; flags_in = f;
        both_reg = br; rpt_use_reg = ur; rpt_imm = ri; rpt_reg = rr;
        same_reg = sr; zc = z; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        busy_cycles = 0;
        for (int i = 0; i < 40 && !done; i++) begin
            if (busy) busy_cycles++;
            @(negedge clk);
        end
        if (!done) check("R10", "done never seen", 0, 1);
    endtask

    task automatic expect_out(input string req, input logic [19:0] r,
                              input logic [3:0] f, input logic we, input int nb);
        check(req, "result", 32'(result), 32'(r));
        check(req, "flags VNZC", 32'(flags_out), 32'(f));
        check(req, "wr_en", 32'(wr_en), 32'(we));
        check(req, "busy cycles", 32'(busy_cycles), 32'(nb));
    endtask

    task automatic t_reset;
        check("R10", "reset result", 32'(result), 0);
        check("R10", "reset flags", 32'(flags_out), 0);
        check("R10", "reset busy/done/wr_en", {29'd0, busy, done, wr_en}, 0);
    endtask

    task automatic t_arith;
        run(4'd1, 2'd1, 20'h00001, 20'h07FFF, 4'b0000, 0, 0, 0, 0, 0, 0);
        expect_out("R3", 20'h08000, 4'b1100, 1, 1);          // signed overflow
        run(4'd1, 2'd0, 20'hABC01, 20'h000FF, 4'b0000, 0, 0, 0, 0, 0, 0);
        expect_out("R1", 20'h00000, 4'b0011, 1, 1);          // 8-bit wrap, masked src
        run(4'd3, 2'd2, 20'h00007, 20'h00005, 4'b0000, 0, 0, 0, 0, 0, 0);
        expect_out("R2", 20'hFFFFE, 4'b0100, 1, 1);          // 20-bit subtract
        run(4'd5, 2'd1, 20'h01234, 20'h01234, 4'b0000, 0, 0, 0, 0, 0, 0);
        expect_out("R5", 20'h00000, 4'b0011, 0, 1);          // compare: no write
        run(4'd2, 2'd1, 20'h00020, 20'h00010, 4'b0001, 0, 0, 0, 0, 0, 0);
        expect_out("R2", 20'h00031, 4'b0000, 1, 1);          // addc uses C
        run(4'd2, 2'd1, 20'h00020, 20'h00010, 4'b0001, 0, 0, 0, 0, 0, 1);
        expect_out("R8", 20'h00031, 4'b0000, 1, 1);          // zc ignored w/o both_reg
        run(4'd2, 2'd1, 20'h00020, 20'h00010, 4'b0001, 1, 0, 0, 0, 0, 1);
        expect_out("R8", 20'h00030, 4'b0000, 1, 1);          // zc masks carry
        run(4'd4, 2'd1, 20'h00001, 20'h00010, 4'b0000, 0, 0, 0, 0, 0, 0);
        expect_out("R2", 20'h0000E, 4'b0001, 1, 1);          // subc with borrow
    endtask

    task automatic t_decimal;
        run(4'd6, 2'd1, 20'h00001, 20'h00199, 4'b0000, 0, 0, 0, 0, 0, 0);
        expect_out("R6", 20'h00200, 4'b0000, 1, 1);
        run(4'd6, 2'd0, 20'h00000, 20'h00099, 4'b1001, 0, 0, 0, 0, 0, 0);
        expect_out("R6", 20'h00000, 4'b0011, 1, 1);          // carry out of 8-bit top
    endtask

    task automatic t_logic;
        run(4'd8, 2'd1, 20'h0F0F0, 20'h08F0F, 4'b1000, 0, 0, 0, 0, 0, 0);
        expect_out("R4", 20'h08000, 4'b0101, 1, 1);
        run(4'd7, 2'd0, 20'h000F0, 20'h0000F, 4'b0000, 0, 0, 0, 0, 0, 0);
        expect_out("R4", 20'h00000, 4'b0010, 0, 1);          // bit test, no write
        run(4'd11, 2'd1, 20'h08001, 20'h08001, 4'b0000, 0, 0, 0, 0, 0, 0);
        expect_out("R4", 20'h00000, 4'b1010, 1, 1);          // xor V
    endtask

    task automatic t_flag_keep;
        run(4'd10, 2'd1, 20'h00F00, 20'h000F0, 4'b1011, 0, 0, 0, 0, 0, 0);
        expect_out("R5", 20'h00FF0, 4'b1011, 1, 1);
        run(4'd9, 2'd1, 20'h000F0, 20'h00FF0, 4'b0101, 0, 0, 0, 0, 0, 0);
        expect_out("R5", 20'h00F00, 4'b0101, 1, 1);
        run(4'd0, 2'd2, 20'h12345, 20'h00000, 4'b0110, 0, 0, 0, 0, 0, 0);
        expect_out("R5", 20'h12345, 4'b0110, 1, 1);
        run(4'd14, 2'd1, 20'h00001, 20'h00002, 4'b1010, 0, 0, 0, 0, 0, 0);
        check("R11", "unused op wr_en", 32'(wr_en), 0);
        check("R11", "unused op flags", 32'(flags_out), 32'(4'b1010));
    endtask

    task automatic t_repeat;
        run(4'd1, 2'd1, 20'h00003, 20'h00010, 4'b0000, 1, 0, 4'd3, 4'd9, 0, 0);
        expect_out("R7", 20'h0001C, 4'b0000, 1, 4);          // immediate count
        run(4'd1, 2'd1, 20'h00001, 20'h00001, 4'b0000, 1, 1, 4'hF, 4'd2, 1, 0);
        expect_out("R9", 20'h00008, 4'b0000, 1, 3);          // reg count, same reg
        run(4'd1, 2'd1, 20'h00001, 20'h00001, 4'b0000, 0, 0, 4'd5, 4'd5, 0, 0);
        expect_out("R7", 20'h00002, 4'b0000, 1, 1);          // repeat needs both_reg
        run(4'd2, 2'd0, 20'h00001, 20'h000FF, 4'b0000, 1, 0, 4'd1, 4'd0, 0, 0);
        expect_out("R9", 20'h00002, 4'b0000, 1, 2);          // carry passes on
        run(4'd2, 2'd0, 20'h00001, 20'h000FF, 4'b0000, 1, 0, 4'd1, 4'd0, 0, 1);
        expect_out("R8", 20'h00001, 4'b0000, 1, 2);          // zc on each iteration
    endtask

    task automatic t_start_while_busy;
        @(negedge clk);
        op = 4'd1; wsel = 2'd1; src_in = 20'h1; dst_in = 20'h0; flags_in = 0;
        both_reg = 1; rpt_use_reg = 0; rpt_imm = 4'd2; same_reg = 0; zc = 0;
        start = 1'b1;
        @(negedge clk);
        src_in = 20'h00100;          // second start while busy
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 40 && !done; i++) @(negedge clk);
        check("R10", "start ignored while busy", 32'(result), 32'h3);
        check("R10", "done strobe", 32'(done), 1);
        @(negedge clk);
        check("R10", "done one cycle", 32'(done), 0);
        check("R10", "idle after", 32'(busy), 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_arith();
        t_decimal();
        t_logic();
        t_flag_keep();
        t_repeat();
        t_start_while_busy();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule